// File: doc/BRIEF.md
# Framed Command Packet Receiver

This block sits behind a serial-link word deserializer and turns the incoming 16-bit word stream into commands for a downstream control state machine. It hunts for a start marker, then collects one framed packet: a packet number, a parameter count, a single command code, the parameter words, a CRC-16 trailer and an end marker. Every packet carries exactly one command, so each accepted packet yields exactly one command hand-off.

A packet is trusted only once it is complete. Parameter words are held in an internal buffer while the packet arrives. They are released downstream with a valid/ready handshake only after the CRC has matched and the end marker has been seen, and a one-cycle done strobe closes the hand-off. A numbering gap, a malformed header, an unknown command, a CRC mismatch or a broken frame drops the packet. The receiver then parks in an error state and raises a sticky error flag with a code for the last fault. A dedicated link-reset marker clears that history and drives a fixed-width reset pulse for the units downstream.

Top module: `cmd_pkt_rx`

## Requirements
- R1: Markers count only on a valid word with the control flag set: start 0x1C3C, end 0x1CFD, link reset 0x1CBC. In the idle state, every other word (data words and other control words) is ignored. It leaves the state at 0 and the error flag clear.
- R2: After the start marker, data words are taken in this order: packet number, parameter count, command code, parameter words, CRC word. The next valid word must then be the end marker. Words with in_valid_i low are skipped at any point.
- R3: The first packet after power-on reset or a link reset is accepted with any packet number. After that, a packet number must equal the last accepted number plus one, modulo 2^16 (0xFFFF is followed by 0x0000). Otherwise error code 1 is raised.
- R4: A parameter count from 0 to 255 is legal, and a count above 255 raises error code 2.
- R5: Command codes 1 to 4 are legal and appear on cmd_id_o during the hand-off. Code 0 or any code above 4 raises error code 3.
- R6: The CRC is CRC-16 with polynomial 0x1021 and start value 0xFFFF. It is taken MSB first, with no reflection and no final inversion, over the number, count, command and parameter words. A trailer that differs raises error code 4.
- R7: A control word anywhere in the body, or a non-end-marker word where the end marker is due, raises error code 5.
- R8: Only after the end marker of a good packet does the state become 2 (hand-off). The parameters then leave on par_data_o in arrival order. A word is held stable while par_valid_o is high and par_ready_i is low. In the cycle after the last word is taken (or in the first hand-off cycle when the count is 0), cmd_done_o is high for exactly one cycle. A dropped packet emits no parameter and no done.
- R9: Any fault sets state 3 (error), sets err_flag_o and loads err_code_o. The flag stays set until a link reset, and later good packets do not clear it. The error state is left only by a start marker, which opens a new packet, or by a link-reset marker.
- R10: A link-reset marker (accepted in states 0, 1 and 3) moves the block to state 4. It drives link_rst_o high for exactly 16 cycles, clears err_flag_o, err_code_o and the packet-number history, and then returns to state 0.
- R11: While in state 2 or 4, every input word is ignored, including start and link-reset markers.
- R12: After power-on reset, rx_state_o is 0, err_flag_o is 0, err_code_o is 0, and par_valid_o, cmd_done_o and link_rst_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Input word present this cycle |
| in_ctl_i | input | 1 | Input word is a control character |
| in_data_i | input | 16 | Input word |
| cmd_id_o | output | 16 | Command code of the packet being handed off |
| cmd_active_o | output | 1 | Hand-off in progress (state 2) |
| par_valid_o | output | 1 | Parameter word available |
| par_ready_i | input | 1 | Downstream takes the parameter word |
| par_data_o | output | 16 | Parameter word |
| cmd_done_o | output | 1 | One-cycle strobe: command fully handed off |
| err_flag_o | output | 1 | Sticky error flag |
| err_code_o | output | 3 | Last fault: 1 number, 2 count, 3 command, 4 CRC, 5 frame |
| rx_state_o | output | 3 | 0 idle, 1 receiving, 2 hand-off, 3 error, 4 link reset |
| link_rst_o | output | 1 | Reset pulse for downstream units |

## Verification
The bench goes after packet-number wrap from 0xFFFF to 0x0000 and the any-number rule right after a link reset. A design that compares without wrap, or that keeps old history, would flag a good packet. It also sends a zero-parameter packet and a maximum 255-parameter packet under a stalling ready pattern. An off-by-one in the count path would drop, repeat or misorder words, or fire done early. It also sends corrupted packets of each fault kind, a recovery packet sent while the error flag is set, and markers sent during the hand-off. A receiver that forwarded before the CRC check, cleared the sticky flag on success, or obeyed markers mid-hand-off would put stray words or strobes on the outputs. The width of the link-reset pulse is counted cycle by cycle.

// File: rtl/cmd_pkt_pkg.sv
// Package: shared constants, state and field types, and the CRC step
// function for the command packet receiver.
package cmd_pkt_pkg;

    localparam logic [15:0] SOP_WORD  = 16'h1C3C;
    localparam logic [15:0] EOP_WORD  = 16'h1CFD;
    localparam logic [15:0] LRST_WORD = 16'h1CBC;

    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_INDEX = 3'd1;
    localparam logic [2:0] ERR_LEN   = 3'd2;
    localparam logic [2:0] ERR_CMD   = 3'd3;
    localparam logic [2:0] ERR_CRC   = 3'd4;
    localparam logic [2:0] ERR_FRAME = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_DELIVER = 3'd2,
        ST_ERROR   = 3'd3,
        ST_RESET   = 3'd4
    } rx_state_e;

    typedef enum logic [2:0] {
        FLD_INDEX = 3'd0,
        FLD_LEN   = 3'd1,
        FLD_CMD   = 3'd2,
        FLD_PARAM = 3'd3,
        FLD_CRC   = 3'd4,
        FLD_EOP   = 3'd5
    } field_e;

    // Advance the CRC register over one 16-bit word, MSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc,
                                               input logic [15:0] word);
        logic [15:0] c;
        c = crc;
        for (int b = 15; b >= 0; b--) begin
            if (c[15] ^ word[b]) c = (c << 1) ^ CRC_POLY;
            else                 c = c << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/cmd_crc16.sv
// CRC-16 accumulator. clr_i reloads the seed; en_i folds in_i into the
// register. Assumes clr_i and en_i are never high in the same cycle.
module cmd_crc16
    import cmd_pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        en_i,
    input  logic [15:0] in_i,
    output logic [15:0] crc_o
);

    logic [15:0] crc_q;

    // Hold the running CRC of the packet body.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) crc_q <= CRC_SEED;
        else if (en_i)       crc_q <= crc16_step(crc_q, in_i);
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/cmd_param_buf.sv
// Parameter store: words are written in order while a packet arrives and
// read back in order during the hand-off. clr_i rewinds both pointers.
// Assumes at most DEPTH-1 words per packet and no write during reading.
module cmd_param_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_adv_i,
    output logic [DW-1:0] rd_data_o,
    output logic [$clog2(DEPTH)-1:0] wr_count_o,
    output logic          empty_o
);

    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;

    // Store incoming parameter words.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_ptr_q] <= wr_data_i;
    end

    // Move write and read pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (wr_en_i)  wr_ptr_q <= wr_ptr_q + 1'b1;
            if (rd_adv_i) rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    assign rd_data_o  = mem[rd_ptr_q];
    assign wr_count_o = wr_ptr_q;
    assign empty_o    = (rd_ptr_q == wr_ptr_q);

endmodule

// File: rtl/cmd_pulse_timer.sv
// Fixed-width pulse generator: start_i loads CYCLES, busy_o stays high
// for exactly CYCLES cycles, last_o marks the final one.
module cmd_pulse_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);

    localparam int TW = $clog2(CYCLES + 1);
    localparam logic [TW-1:0] LOAD = TW'(CYCLES);

    logic [TW-1:0] cnt_q;

    // Count the pulse down from its load value.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start_i)       cnt_q <= LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
    assign last_o = (cnt_q == TW'(1));

endmodule

// File: rtl/cmd_pkt_rx.sv
// Framed command packet receiver. Parses start marker, packet number,
// parameter count, command code, parameters, CRC and end marker; checks
// numbering, count, command, CRC and framing; releases the command only
// after the whole packet has checked good. Assumes the sender waits for
// cmd_done_o before sending the next packet (words are ignored in hand-off).
module cmd_pkt_rx
    import cmd_pkt_pkg::*;
#(
    parameter int MAX_PARAMS = 255,
    parameter int NUM_CMDS   = 4,
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid_i,
    input  logic        in_ctl_i,
    input  logic [15:0] in_data_i,
    output logic [15:0] cmd_id_o,
    output logic        cmd_active_o,
    output logic        par_valid_o,
    input  logic        par_ready_i,
    output logic [15:0] par_data_o,
    output logic        cmd_done_o,
    output logic        err_flag_o,
    output logic [2:0]  err_code_o,
    output logic [2:0]  rx_state_o,
    output logic        link_rst_o
);

    localparam int BUF_DEPTH = MAX_PARAMS + 1;
    localparam int CW        = $clog2(BUF_DEPTH);
    localparam logic [15:0] LEN_LIMIT = 16'(MAX_PARAMS);
    localparam logic [15:0] CMD_LAST  = 16'(NUM_CMDS);

    rx_state_e     state_q, state_d;
    field_e        fld_q, fld_d;
    logic [15:0]   last_idx_q;
    logic          have_idx_q;
    logic [15:0]   pkt_idx_q;
    logic [CW-1:0] plen_q;
    logic [15:0]   cmd_q;
    logic          err_flag_q;
    logic [2:0]    err_code_q;

    logic          is_sop, is_eop, is_lrst;
    logic          start_pkt, goto_reset, accept_pkt;
    logic          err_set;
    logic [2:0]    err_new;
    logic          crc_en, buf_wr;
    logic [15:0]   crc_w;
    logic [15:0]   buf_rd;
    logic [CW-1:0] buf_cnt;
    logic          buf_empty;
    logic          rst_busy, rst_last;
    logic          hand_take;

    assign is_sop  = in_valid_i && in_ctl_i && (in_data_i == SOP_WORD);
    assign is_eop  = in_valid_i && in_ctl_i && (in_data_i == EOP_WORD);
    assign is_lrst = in_valid_i && in_ctl_i && (in_data_i == LRST_WORD);

    // Decide the next state, field and side effects of the current word.
    always_comb begin
        state_d    = state_q;
        fld_d      = fld_q;
        start_pkt  = 1'b0;
        goto_reset = 1'b0;
        accept_pkt = 1'b0;
        err_set    = 1'b0;
        err_new    = ERR_NONE;
        crc_en     = 1'b0;
        buf_wr     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ERROR: begin
                if (is_lrst)     goto_reset = 1'b1;
                else if (is_sop) start_pkt  = 1'b1;
            end
            ST_READ: begin
                if (is_lrst) begin
                    goto_reset = 1'b1;
                end else if (in_valid_i) begin
                    if (in_ctl_i && fld_q != FLD_EOP) begin
                        err_set = 1'b1;
                        err_new = ERR_FRAME;
                    end else begin
                        unique case (fld_q)
                            FLD_INDEX: begin
                                if (have_idx_q && in_data_i != last_idx_q + 16'd1) begin
                                    err_set = 1'b1;
                                    err_new = ERR_INDEX;
                                end else begin
                                    crc_en = 1'b1;
                                    fld_d  = FLD_LEN;
                                end
                            end
                            FLD_LEN: begin
                                if (in_data_i > LEN_LIMIT) begin
                                    err_set = 1'b1;
                                    err_new = ERR_LEN;
                                end else begin
                                    crc_en = 1'b1;
                                    fld_d  = FLD_CMD;
                                end
                            end
                            FLD_CMD: begin
                                if (in_data_i == 16'd0 || in_data_i > CMD_LAST) begin
                                    err_set = 1'b1;
                                    err_new = ERR_CMD;
                                end else begin
                                    crc_en = 1'b1;
                                    fld_d  = (plen_q == '0) ? FLD_CRC : FLD_PARAM;
                                end
                            end
                            FLD_PARAM: begin
                                crc_en = 1'b1;
                                buf_wr = 1'b1;
                                if (buf_cnt + CW'(1) == plen_q) fld_d = FLD_CRC;
                            end
                            FLD_CRC: begin
                                if (in_data_i != crc_w) begin
                                    err_set = 1'b1;
                                    err_new = ERR_CRC;
                                end else begin
                                    fld_d = FLD_EOP;
                                end
                            end
                            default: begin
                                if (is_eop) begin
                                    accept_pkt = 1'b1;
                                end else begin
                                    err_set = 1'b1;
                                    err_new = ERR_FRAME;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_DELIVER: begin
                if (buf_empty) state_d = ST_IDLE;
            end
            default: begin
                if (rst_last) state_d = ST_IDLE;
            end
        endcase
        if (goto_reset) state_d = ST_RESET;
        if (start_pkt) begin
            state_d = ST_READ;
            fld_d   = FLD_INDEX;
        end
        if (err_set)    state_d = ST_ERROR;
        if (accept_pkt) state_d = ST_DELIVER;
    end

    // Register the receive state and the current field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fld_q   <= FLD_INDEX;
        end else begin
            state_q <= state_d;
            fld_q   <= fld_d;
        end
    end

    // Latch the header fields of the packet being received.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_idx_q <= '0;
            plen_q    <= '0;
            cmd_q     <= '0;
        end else if (state_q == ST_READ && in_valid_i && !in_ctl_i) begin
            if (fld_q == FLD_INDEX) pkt_idx_q <= in_data_i;
            if (fld_q == FLD_LEN)   plen_q    <= in_data_i[CW-1:0];
            if (fld_q == FLD_CMD)   cmd_q     <= in_data_i;
        end
    end

    // Track the number of the last accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n || goto_reset) begin
            last_idx_q <= '0;
            have_idx_q <= 1'b0;
        end else if (accept_pkt) begin
            last_idx_q <= pkt_idx_q;
            have_idx_q <= 1'b1;
        end
    end

    // Keep the sticky error flag and the code of the last fault.
    always_ff @(posedge clk) begin
        if (!rst_n || goto_reset) begin
            err_flag_q <= 1'b0;
            err_code_q <= ERR_NONE;
        end else if (err_set) begin
            err_flag_q <= 1'b1;
            err_code_q <= err_new;
        end
    end

    cmd_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_pkt),
        .en_i  (crc_en),
        .in_i  (in_data_i),
        .crc_o (crc_w)
    );

    assign hand_take = (state_q == ST_DELIVER) && !buf_empty && par_ready_i;

    cmd_param_buf #(
        .DW    (16),
        .DEPTH (BUF_DEPTH)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_pkt),
        .wr_en_i    (buf_wr),
        .wr_data_i  (in_data_i),
        .rd_adv_i   (hand_take),
        .rd_data_o  (buf_rd),
        .wr_count_o (buf_cnt),
        .empty_o    (buf_empty)
    );

    cmd_pulse_timer #(
        .CYCLES (RST_CYCLES)
    ) u_rst_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (goto_reset),
        .busy_o  (rst_busy),
        .last_o  (rst_last)
    );

    assign cmd_id_o     = cmd_q;
    assign cmd_active_o = (state_q == ST_DELIVER);
    assign par_valid_o  = (state_q == ST_DELIVER) && !buf_empty;
    assign par_data_o   = buf_rd;
    assign cmd_done_o   = (state_q == ST_DELIVER) && buf_empty;
    assign err_flag_o   = err_flag_q;
    assign err_code_o   = err_code_q;
    assign rx_state_o   = state_q;
    assign link_rst_o   = rst_busy;

endmodule

// File: rtl/cmd_pkt_rx_chk.sv
// Checker for cmd_pkt_rx: temporal rules on its ports. Bound to every
// instance of the receiver by the bind statement at the end of this file.
module cmd_pkt_rx_chk
    import cmd_pkt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid_i,
    input logic        in_ctl_i,
    input logic [15:0] in_data_i,
    input logic        par_valid_o,
    input logic        par_ready_i,
    input logic [15:0] par_data_o,
    input logic        cmd_done_o,
    input logic        err_flag_o,
    input logic [2:0]  err_code_o,
    input logic [2:0]  rx_state_o,
    input logic        link_rst_o
);

    logic [7:0] run_q;

    // Count consecutive high cycles of the link reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (link_rst_o) run_q <= run_q + 8'd1;
        else                 run_q <= '0;
    end

    // R8: hand-off starts only right after an end marker.
    assert_deliver_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_state_o == ST_DELIVER) |->
            $past(in_valid_i && in_ctl_i && in_data_i == EOP_WORD));

    // R8: done is a single-cycle strobe.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_o |=> !cmd_done_o);

    // R8: a stalled parameter word holds.
    assert_par_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid_o && !par_ready_i |=> par_valid_o && $stable(par_data_o));

    // R9: the error flag only drops on entry to link reset.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag_o |=> (err_flag_o || rx_state_o == ST_RESET));

    // R9: entering the error state comes with a flag and a code.
    assert_err_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_state_o == ST_ERROR) |-> (err_flag_o && err_code_o != ERR_NONE));

    // R10: link reset pulse lasts exactly RST_CYCLES cycles.
    assert_rst_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_rst_o) |-> (run_q == 8'(RST_CYCLES)));

    assert_rst_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst_o |-> (run_q < 8'(RST_CYCLES)));

    // R11: hand-off is not interrupted by input words.
    assert_hold_deliver_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state_o == ST_DELIVER && !cmd_done_o) |=> (rx_state_o == ST_DELIVER));

endmodule

bind cmd_pkt_rx cmd_pkt_rx_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_ctl_i    (in_ctl_i),
    .in_data_i   (in_data_i),
    .par_valid_o (par_valid_o),
    .par_ready_i (par_ready_i),
    .par_data_o  (par_data_o),
    .cmd_done_o  (cmd_done_o),
    .err_flag_o  (err_flag_o),
    .err_code_o  (err_code_o),
    .rx_state_o  (rx_state_o),
    .link_rst_o  (link_rst_o)
);

// File: tb/cmd_pkt_rx_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the packet driver queues expected parameters and
// commands, a monitor compares them against the hand-off outputs.
module cmd_pkt_rx_tb_top;

    localparam logic [15:0] SOP  = 16'h1C3C;
    localparam logic [15:0] EOP  = 16'h1CFD;
    localparam logic [15:0] LRST = 16'h1CBC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ctl = 1'b0;
    logic [15:0] in_data = '0;
    logic        par_ready = 1'b0;
    logic        hold_ready = 1'b0;
    logic [15:0] cmd_id;
    logic        cmd_active;
    logic        par_valid;
    logic [15:0] par_data;
    logic        cmd_done;
    logic        err_flag;
    logic [2:0]  err_code;
    logic [2:0]  rx_state;
    logic        link_rst;

    int total = 0;
    int bad = 0;
    int dones_seen = 0;
    int dones_exp = 0;
    bit finished = 1'b0;
    logic [15:0] exp_par[$];
    logic [15:0] exp_cmd[$];

    always #2.5 clk = ~clk;

    cmd_pkt_rx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid_i   (in_valid),
        .in_ctl_i     (in_ctl),
        .in_data_i    (in_data),
        .cmd_id_o     (cmd_id),
        .cmd_active_o (cmd_active),
        .par_valid_o  (par_valid),
        .par_ready_i  (par_ready),
        .par_data_o   (par_data),
        .cmd_done_o   (cmd_done),
        .err_flag_o   (err_flag),
        .err_code_o   (err_code),
        .rx_state_o   (rx_state),
        .link_rst_o   (link_rst)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r;
        r = c ^ w;
        for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    // Present one word for one cycle; returns at the following negedge.
    task automatic put(input logic c, input logic [15:0] d);
        in_valid = 1'b1;
        in_ctl   = c;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        in_ctl   = 1'b0;
    endtask

    // mode 0 good, 1 bad CRC, 2 data word instead of end marker.
    task automatic send_pkt(input logic [15:0] idx, input logic [15:0] len,
                            input logic [15:0] cmd, input int seed, input int mode,
                            input int gap, input bit ok);
        logic [15:0] words[$];
        logic [15:0] crc;
        int n;
        n = (len > 16'd255) ? 0 : int'(len);
        words.push_back(idx);
        words.push_back(len);
        words.push_back(cmd);
        for (int i = 0; i < n; i++) words.push_back(16'(seed * 977 + i * 4099 + 3));
        crc = 16'hFFFF;
        foreach (words[i]) crc = ref_crc(crc, words[i]);
        if (ok) begin
            for (int i = 3; i < words.size(); i++) exp_par.push_back(words[i]);
            exp_cmd.push_back(cmd);
            dones_exp++;
        end
        put(1'b1, SOP);
        foreach (words[i]) begin
            put(1'b0, words[i]);
            repeat (gap) @(negedge clk);
        end
        put(1'b0, (mode == 1) ? (crc ^ 16'h0001) : crc);
        if (mode == 2) put(1'b0, 16'h0BAD);
        else           put(1'b1, EOP);
    endtask

    task automatic wait_idle();
        int k = 0;
        while (rx_state != 3'd0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
    endtask

    // Downstream ready: pseudo-random stalls unless held low.
    initial begin
        logic [7:0] lf = 8'hA5;
        forever begin
            @(posedge clk);
            #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            par_ready = hold_ready ? 1'b0 : (lf[0] | lf[1]);
        end
    end

    // Monitor: pop and compare every handed-off word and command.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (par_valid && par_ready) begin
                if (exp_par.size() == 0) chk(1'b0, "R8", "unexpected param", int'(par_data), 0);
                else begin
                    logic [15:0] e;
                    e = exp_par.pop_front();
                    chk(par_data == e, "R8", "param word", int'(par_data), int'(e));
                end
            end
            if (cmd_done) begin
                dones_seen++;
                if (exp_cmd.size() == 0) chk(1'b0, "R8", "unexpected done", int'(cmd_id), 0);
                else begin
                    logic [15:0] e;
                    e = exp_cmd.pop_front();
                    chk(cmd_id == e, "R5", "command id", int'(cmd_id), int'(e));
                    chk(exp_par.size() == 0, "R8", "params left at done", exp_par.size(), 0);
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(rx_state == 3'd0, "R12", "state after reset", rx_state, 0);
        chk(err_flag == 1'b0, "R12", "err flag after reset", err_flag, 0);
        chk(err_code == 3'd0, "R12", "err code after reset", err_code, 0);
        chk(!par_valid && !cmd_done && !link_rst, "R12", "outputs after reset",
            {par_valid, cmd_done, link_rst}, 0);

        // R1: stray words in idle are ignored
        put(1'b0, SOP);
        put(1'b1, EOP);
        put(1'b1, 16'h1C3D);
        chk(rx_state == 3'd0, "R1", "state after stray words", rx_state, 0);
        chk(err_flag == 1'b0, "R1", "flag after stray words", err_flag, 0);

        // R2 R4 R5 R6 R8: good packets, various sizes and gaps
        send_pkt(16'd100, 16'd3, 16'd1, 1, 0, 0, 1'b1);
        wait_idle();
        send_pkt(16'd101, 16'd0, 16'd2, 2, 0, 0, 1'b1);
        wait_idle();
        send_pkt(16'd102, 16'd7, 16'd4, 3, 0, 2, 1'b1);
        wait_idle();
        chk(err_flag == 1'b0, "R2", "no error on good packets", err_flag, 0);

        // R3: numbering gap
        send_pkt(16'd104, 16'd2, 16'd1, 4, 0, 0, 1'b0);
        chk(rx_state == 3'd3, "R3", "state after number gap", rx_state, 3);
        chk(err_code == 3'd1, "R3", "code after number gap", err_code, 1);

        // R9: recovery by start marker, flag stays set
        send_pkt(16'd103, 16'd2, 16'd3, 5, 0, 0, 1'b1);
        wait_idle();
        chk(err_flag == 1'b1, "R9", "flag sticky after good packet", err_flag, 1);
        chk(err_code == 3'd1, "R9", "code kept after good packet", err_code, 1);

        // R6: bad CRC
        send_pkt(16'd104, 16'd2, 16'd2, 6, 1, 0, 1'b0);
        chk(rx_state == 3'd3 && err_code == 3'd4, "R6", "bad crc state/code",
            {rx_state, err_code}, {3'd3, 3'd4});
        // R5: unknown command
        send_pkt(16'd104, 16'd1, 16'd5, 7, 0, 0, 1'b0);
        chk(err_code == 3'd3, "R5", "unknown command code", err_code, 3);
        // R4: count above limit
        send_pkt(16'd104, 16'd300, 16'd1, 8, 0, 0, 1'b0);
        chk(err_code == 3'd2, "R4", "oversize count code", err_code, 2);
        // R7: missing end marker
        send_pkt(16'd104, 16'd1, 16'd1, 9, 2, 0, 1'b0);
        chk(rx_state == 3'd3 && err_code == 3'd5, "R7", "missing end marker",
            {rx_state, err_code}, {3'd3, 3'd5});
        // R7: control word inside body
        put(1'b1, SOP);
        put(1'b0, 16'd104);
        put(1'b1, 16'h1C7C);
        chk(err_code == 3'd5, "R7", "control word in body", err_code, 5);

        // R10: link reset
        put(1'b1, LRST);
        chk(rx_state == 3'd4, "R10", "state on link reset", rx_state, 4);
        begin
            int c = 0;
            while (link_rst && c < 100) begin
                c++;
                @(negedge clk);
            end
            chk(c == 16, "R10", "link reset width", c, 16);
        end
        chk(rx_state == 3'd0, "R10", "state after link reset", rx_state, 0);
        chk(err_flag == 1'b0 && err_code == 3'd0, "R10", "error cleared",
            {err_flag, err_code}, 0);

        // R3: any number after reset, then wrap
        send_pkt(16'hFFFF, 16'd1, 16'd4, 10, 0, 0, 1'b1);
        wait_idle();
        // R4: maximum count 255
        send_pkt(16'h0000, 16'd255, 16'd1, 11, 0, 0, 1'b1);
        wait_idle();
        chk(err_flag == 1'b0, "R3", "wrap and max count accepted", err_flag, 0);

        // R11: input ignored during hand-off
        hold_ready = 1'b1;
        send_pkt(16'd1, 16'd2, 16'd2, 12, 0, 0, 1'b1);
        put(1'b1, SOP);
        put(1'b0, 16'd2);
        put(1'b1, LRST);
        chk(rx_state == 3'd2, "R11", "still in hand-off", rx_state, 2);
        chk(!link_rst && par_valid, "R11", "no reset, word pending",
            {link_rst, par_valid}, 1);
        hold_ready = 1'b0;
        wait_idle();
        chk(err_flag == 1'b0 && rx_state == 3'd0, "R11", "idle clean after hand-off",
            {err_flag, rx_state}, 0);
        send_pkt(16'd2, 16'd1, 16'd3, 13, 0, 0, 1'b1);
        wait_idle();

        // R8: one done per accepted packet, none for rejected ones
        repeat (4) @(negedge clk);
        chk(dones_seen == dones_exp, "R8", "done count", dones_seen, dones_exp);
        chk(exp_par.size() == 0, "R8", "all params delivered", exp_par.size(), 0);
        summary();
    end

endmodule